// File: doc/BRIEF.md
# Power Partition Gating Controller

This controller switches power to as many as 32 numbered logic partitions and manages their isolation clamps. Software reaches four 32-bit registers through a simple register port. Writes are synchronous and reads are combinational. The four registers are a toggle command, a clamp-release command, a power status bitmap and a clamp status bitmap. The block drives a power-enable bit and a clamp-enable bit for each partition.

A power change is one command, addressed by partition number, that inverts that partition's power. The enable output moves at once. A self-clearing busy flag stays up for a parameterized settling time, and the status bitmap updates when the flag drops. Only one power change is in flight at a time.

Clamp release is a separate one-hot command. Requested bits stay visible as pending while they wait. They are released one at a time, lowest partition first, and each release takes its own parameterized settling time. Release requests for unpowered partitions are dropped. Removing power re-clamps the partition at once and cancels any release still pending for it.

Top module: `pgate_ctrl`

## Requirements
- R1: After reset, both bitmaps read as follows: power status is all zero and clamp status is all ones. The toggle and clamp-release registers read zero, `pwr_en` is zero and `clamp_en` is all ones.
- R2: A write to the toggle register (byte offset 0x030) with bit 8 set accepts the partition number in bits 4:0. `pwr_en[id]` inverts on that clock edge. On reads, bit 8 is 1 for exactly PWR_CYC cycles and then drops to 0. Bits 4:0 read back the last accepted partition number.
- R3: The power status register (offset 0x038) shows bit n = 1 when partition n is powered. The selected bit changes on the edge where the busy bit drops and not before.
- R4: A toggle write is ignored if it arrives while the busy bit is set, or if its bit 8 is 0.
- R5: A write to the clamp-release register (offset 0x034) sets a pending bit for each requested partition that is powered and still clamped. A pending bit reads 1 until that partition's release completes.
- R6: A release request for an unpowered partition is dropped. Its clamp status bit (offset 0x02C, bit n = 1 while clamped) and its `clamp_en` output stay 1.
- R7: Pending releases are served one at a time, lowest partition number first. A release starts one cycle after the engine finds it idle with work pending. It completes CLAMP_CYC cycles later, and on that edge the pending bit, the clamp status bit and `clamp_en` all clear.
- R8: An accepted toggle that powers a partition off sets that partition's clamp on the same edge. The same edge cancels any pending release for that partition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pwr_en | output | NPART | Power switch enable per partition |
| clamp_en | output | NPART | Isolation clamp enable per partition |

## Verification
The toggle command is tried with three patterns, and each tells apart a different mistake:
- A clean command tells apart an enable that moves at acceptance from a status bit that moves at completion.
- A second command issued during the busy window tells whether a busy write is dropped or merged.
- A command with bit 8 clear tells whether the start bit gates acceptance.

The clamp-release command is tried with four patterns:
- A single bit measures the exact release latency.
- A bit for an unpowered partition checks that illegal requests are dropped.
- A multi-bit request that also names an already-released partition checks both the lowest-first order and the filtering.
- A power-off issued while a release is in service and another is pending checks that re-clamping wins over the queued release.

// File: rtl/pgate_pkg.sv
package pgate_pkg;
   // register byte offsets; software depends on these
   localparam logic [11:0] OFS_CLAMP_ST = 12'h02C;
   localparam logic [11:0] OFS_TOGGLE   = 12'h030;
   localparam logic [11:0] OFS_RELEASE  = 12'h034;
   localparam logic [11:0] OFS_POWER_ST = 12'h038;
   localparam int          START_BIT    = 8;
   localparam int          PID_W        = 5;
   typedef logic [PID_W-1:0] pid_t;
endpackage

// File: rtl/pgate_settle.sv
// Settling timer: busy for exactly CYCLES cycles after start.
module pgate_settle #(
   parameter int CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

   logic busy_q;
   assign busy = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          busy_q <= 1'b0;
      else if (start)      busy_q <= 1'b1;
      else if (done)       busy_q <= 1'b0;
   end

   generate
      if (CYCLES == 1) begin : g_single
         assign done = busy_q;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                       cnt_q <= '0;
            else if (start)                   cnt_q <= CNT_W'(CYCLES - 1);
            else if (busy_q && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
         end
         assign done = busy_q && (cnt_q == '0);
      end
   endgenerate
endmodule

// File: rtl/pgate_toggle.sv
// Power toggle engine: one partition change in flight at a time.
module pgate_toggle
   import pgate_pkg::*;
#(
   parameter int NPART  = 32,
   parameter int CYCLES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  pid_t             cmd_id,
   output logic             busy,
   output pid_t             id_q,
   output logic [NPART-1:0] pwr_st,
   output logic [NPART-1:0] pwr_en,
   output logic [NPART-1:0] off_kill,
   output logic [NPART-1:0] tgt_mask
);
   logic             accept, done;
   logic [NPART-1:0] sel, cur;

   assign accept   = cmd_wr && !busy && (32'(cmd_id) < NPART);
   assign sel      = NPART'(1) << cmd_id;
   assign cur      = NPART'(1) << id_q;
   assign off_kill = accept ? (sel & pwr_en) : '0;
   assign tgt_mask = busy ? cur : '0;

   pgate_settle #(.CYCLES(CYCLES)) u_settle (
      .clk(clk), .rst_n(rst_n), .start(accept), .busy(busy), .done(done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         id_q   <= '0;
         pwr_en <= '0;
         pwr_st <= '0;
      end else begin
         if (accept) begin
            id_q   <= cmd_id;
            pwr_en <= pwr_en ^ sel;
         end
         if (done) pwr_st <= pwr_st ^ cur;
      end
   end
endmodule

// File: rtl/pgate_clamp.sv
// Clamp release engine: serial, lowest partition first.
module pgate_clamp #(
   parameter int NPART  = 32,
   parameter int CYCLES = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [NPART-1:0] cmd_bits,
   input  logic [NPART-1:0] allow,
   input  logic [NPART-1:0] kill,
   output logic [NPART-1:0] clamp_st,
   output logic [NPART-1:0] pending
);
   localparam int IDX_W = $clog2(NPART);

   function automatic logic [IDX_W-1:0] lowest(input logic [NPART-1:0] v);
      lowest = '0;
      for (int i = NPART - 1; i >= 0; i--)
         if (v[i]) lowest = IDX_W'(i);
   endfunction

   logic             srv_busy, srv_done, srv_start;
   logic [IDX_W-1:0] srv_idx;
   logic [NPART-1:0] done_bit, new_bits;

   assign srv_start = !srv_busy && (pending != '0);
   assign done_bit  = srv_done ? ((NPART'(1) << srv_idx) & pending) : '0;
   assign new_bits  = cmd_wr ? (cmd_bits & allow & clamp_st) : '0;

   pgate_settle #(.CYCLES(CYCLES)) u_settle (
      .clk(clk), .rst_n(rst_n), .start(srv_start), .busy(srv_busy), .done(srv_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         srv_idx  <= '0;
         pending  <= '0;
         clamp_st <= '1;
      end else begin
         if (srv_start) srv_idx <= lowest(pending);
         // kill is applied last so re-clamping wins over a completing release
         pending  <= (pending | new_bits) & ~done_bit & ~kill;
         clamp_st <= (clamp_st & ~done_bit) | kill;
      end
   end
endmodule

// File: rtl/pgate_ctrl.sv
module pgate_ctrl
   import pgate_pkg::*;
#(
   parameter int NPART     = 32,
   parameter int PWR_CYC   = 8,
   parameter int CLAMP_CYC = 5,
   parameter int ADDR_W    = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NPART-1:0]  pwr_en,
   output logic [NPART-1:0]  clamp_en
);
   generate
      if (NPART < 2 || NPART > 32) begin : g_bad_npart
         $error("NPART must be in 2..32");
      end
      if (PWR_CYC < 1 || CLAMP_CYC < 1) begin : g_bad_cyc
         $error("settling times must be at least one cycle");
      end
      if (ADDR_W < 6 || ADDR_W > 12) begin : g_bad_addr
         $error("ADDR_W must be in 6..12");
      end
   endgenerate

   logic             hit_tgl, hit_rel;
   logic             tgl_busy;
   pid_t             tgl_id;
   logic [NPART-1:0] pwr_st, off_kill, tgt_mask, clamp_st, pending;

   assign hit_tgl = bus_wr && (bus_addr == OFS_TOGGLE[ADDR_W-1:0]) && bus_wdata[START_BIT];
   assign hit_rel = bus_wr && (bus_addr == OFS_RELEASE[ADDR_W-1:0]);

   pgate_toggle #(.NPART(NPART), .CYCLES(PWR_CYC)) u_toggle (
      .clk(clk), .rst_n(rst_n), .cmd_wr(hit_tgl), .cmd_id(bus_wdata[PID_W-1:0]),
      .busy(tgl_busy), .id_q(tgl_id), .pwr_st(pwr_st), .pwr_en(pwr_en),
      .off_kill(off_kill), .tgt_mask(tgt_mask)
   );

   pgate_clamp #(.NPART(NPART), .CYCLES(CLAMP_CYC)) u_clamp (
      .clk(clk), .rst_n(rst_n), .cmd_wr(hit_rel), .cmd_bits(bus_wdata[NPART-1:0]),
      .allow(pwr_st & ~tgt_mask), .kill(off_kill),
      .clamp_st(clamp_st), .pending(pending)
   );

   assign clamp_en = clamp_st;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == OFS_TOGGLE[ADDR_W-1:0])
         bus_rdata = {23'd0, tgl_busy, 3'd0, tgl_id};
      else if (bus_addr == OFS_RELEASE[ADDR_W-1:0])
         bus_rdata = 32'(pending);
      else if (bus_addr == OFS_POWER_ST[ADDR_W-1:0])
         bus_rdata = 32'(pwr_st);
      else if (bus_addr == OFS_CLAMP_ST[ADDR_W-1:0])
         bus_rdata = 32'(clamp_st);
   end
endmodule

// File: rtl/pgate_chk.sv
module pgate_chk #(
   parameter int NPART = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic [4:0]       id_q,
   input logic [NPART-1:0] pwr_st,
   input logic [NPART-1:0] pwr_en,
   input logic [NPART-1:0] clamp_st,
   input logic [NPART-1:0] pending
);
   assert_en_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (pwr_en == pwr_st));

   assert_one_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_st != $past(pwr_st)) |->
         ($past(busy) && !busy && $countones(pwr_st ^ $past(pwr_st)) == 1));

   assert_id_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(id_q));

   assert_pending_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pending & ~(pwr_st & clamp_st)) == '0);

   assert_clamp_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (~pwr_st & ~clamp_st) == '0);
endmodule

bind pgate_ctrl pgate_chk #(.NPART(NPART)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(tgl_busy), .id_q(tgl_id),
   .pwr_st(pwr_st), .pwr_en(pwr_en), .clamp_st(clamp_st), .pending(pending)
);

// File: tb/pgate_ctrl_test.sv
module pgate_ctrl_test;
   localparam int CLK_P = 10;
   localparam int NP    = 32;
   localparam int PC    = 4;
   localparam int CC    = 3;
   localparam logic [11:0] A_CLMP = 12'h02C, A_TGL = 12'h030,
                           A_REL  = 12'h034, A_PWR = 12'h038;

   logic          clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0, bus_rdata;
   logic [NP-1:0] pwr_en, clamp_en;
   int n_chk = 0, n_fail = 0;
   logic [31:0] exp_pwr = '0, exp_clamp = '1;

   always #(CLK_P/2) clk = ~clk;

   pgate_ctrl #(.NPART(NP), .PWR_CYC(PC), .CLAMP_CYC(CC), .ADDR_W(12)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_en(pwr_en), .clamp_en(clamp_en)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic step(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic power_toggle(input int id);
      wr(A_TGL, 32'h100 | id);
      step(PC);
      exp_pwr[id] = ~exp_pwr[id];
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rst_n = 1'b0; step(3); rst_n = 1'b1; step(1);
      rd(A_PWR, d);  chk("R1 power status", d, 32'h0);
      rd(A_CLMP, d); chk("R1 clamp status", d, 32'hFFFF_FFFF);
      rd(A_TGL, d);  chk("R1 toggle reg", d, 32'h0);
      rd(A_REL, d);  chk("R1 release reg", d, 32'h0);
      chk("R1 pwr_en", pwr_en, 32'h0);
      chk("R1 clamp_en", clamp_en, 32'hFFFF_FFFF);
   endtask

   task automatic t_power_on;
      logic [31:0] d;
      wr(A_TGL, 32'h103);
      chk("R2 pwr_en moves at accept", pwr_en, 32'h8);
      rd(A_TGL, d); chk("R2 busy readback", d, 32'h103);
      rd(A_PWR, d); chk("R3 status before completion", d, 32'h0);
      step(PC - 1);
      rd(A_TGL, d); chk("R2 busy at last cycle", d, 32'h103);
      rd(A_PWR, d); chk("R3 status still old", d, 32'h0);
      step(1);
      rd(A_TGL, d); chk("R2 busy cleared", d, 32'h003);
      rd(A_PWR, d); chk("R3 status updated", d, 32'h8);
      chk("R3 clamp kept after power on", clamp_en, 32'hFFFF_FFFF);
      exp_pwr = 32'h8;
   endtask

   task automatic t_ignored;
      logic [31:0] d;
      wr(A_TGL, 32'h107);
      wr(A_TGL, 32'h109);
      chk("R4 busy write ignored pwr_en", pwr_en, 32'h88);
      rd(A_TGL, d); chk("R4 busy write ignored id", d, 32'h107);
      step(PC - 1);
      rd(A_PWR, d); chk("R4 only first toggle done", d, 32'h88);
      wr(A_TGL, 32'h009);
      rd(A_TGL, d); chk("R4 no-start write ignored", d, 32'h007);
      step(PC + 1);
      rd(A_PWR, d); chk("R4 no-start leaves status", d, 32'h88);
      exp_pwr = 32'h88;
   endtask

   task automatic t_illegal;
      logic [31:0] d;
      wr(A_REL, 32'h1000);
      rd(A_REL, d); chk("R6 unpowered request dropped", d, 32'h0);
      step(CC + 3);
      rd(A_CLMP, d); chk("R6 clamp stays", d, 32'hFFFF_FFFF);
      chk("R6 clamp_en stays", clamp_en, 32'hFFFF_FFFF);
   endtask

   task automatic t_release;
      logic [31:0] d;
      wr(A_REL, 32'h8);
      rd(A_REL, d); chk("R5 pending set", d, 32'h8);
      step(CC);
      rd(A_REL, d); chk("R5 pending until done", d, 32'h8);
      rd(A_CLMP, d); chk("R7 clamp held until done", d, 32'hFFFF_FFFF);
      step(1);
      rd(A_REL, d); chk("R5 pending cleared", d, 32'h0);
      rd(A_CLMP, d); chk("R7 clamp released", d, 32'hFFFF_FFF7);
      chk("R7 clamp_en released", clamp_en, 32'hFFFF_FFF7);
      exp_clamp = 32'hFFFF_FFF7;
   endtask

   task automatic t_order;
      logic [31:0] d;
      power_toggle(20);
      wr(A_REL, 32'h0010_0088);
      rd(A_REL, d); chk("R5 only powered clamped bits pend", d, 32'h0010_0080);
      step(CC + 1);
      rd(A_REL, d); chk("R7 lowest served first", d, 32'h0010_0000);
      rd(A_CLMP, d); chk("R7 bit7 released first", d, 32'hFFFF_FF77);
      step(CC + 1);
      rd(A_REL, d); chk("R7 second served", d, 32'h0);
      rd(A_CLMP, d); chk("R7 bit20 released", d, 32'hFFEF_FF77);
      exp_clamp = 32'hFFEF_FF77;
   endtask

   task automatic t_power_off;
      logic [31:0] d;
      wr(A_TGL, 32'h103);
      chk("R8 reclamp at accept", clamp_en, exp_clamp | 32'h8);
      step(PC);
      rd(A_PWR, d); chk("R8 partition off", d, exp_pwr & ~32'h8);
      exp_pwr[3] = 1'b0; exp_clamp[3] = 1'b1;
      power_toggle(14);
      power_toggle(15);
      wr(A_REL, 32'h0000_C000);
      wr(A_TGL, 32'h10F);
      rd(A_REL, d); chk("R8 pending cancelled", d, 32'h0000_4000);
      chk("R8 bit15 clamped", clamp_en[15], 1'b1);
      step(PC + CC + 3);
      exp_pwr[15] = 1'b0; exp_clamp[14] = 1'b0;
      rd(A_PWR, d); chk("R8 status after off", d, exp_pwr);
      rd(A_CLMP, d); chk("R8 clamp status", d, exp_clamp);
      rd(A_REL, d); chk("R8 nothing pending", d, 32'h0);
   endtask

   initial begin
      t_reset();
      t_power_on();
      t_ignored();
      t_illegal();
      t_release();
      t_order();
      t_power_off();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_P * 20000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule